// File: doc/BRIEF.md
# Shift, Rotate and Status-Flag Unit

This block is the bit-manipulation slice of an 8-bit processor datapath. Each cycle it takes one register operand, the current status byte, a 3-bit operation code, a bit index and a flag index. It produces a result byte and an updated status byte. Both outputs are registered on the rising clock edge, so every operation completes in exactly one clock.

The operations are these: rotate left or right through the carry flag, arithmetic shift right, nibble swap, setting or clearing any single status flag, copying an operand bit into the transfer flag T, and writing T into a bit of the result. Each operation touches only its own fixed set of flags and passes the other status bits through unchanged. Instruction decode, the register file and memory access belong to the surrounding datapath.

Status bit positions, from bit 0 upward: C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. Operation codes: 0 rotate left, 1 rotate right, 2 arithmetic shift right, 3 nibble swap, 4 flag set, 5 flag clear, 6 bit to T, 7 T to bit.

Top module: `bitop_flag_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result` and `sreg_out` become 0 after that edge.
- R2: The outputs after a rising edge depend only on the inputs sampled at that edge. Back-to-back operations each show their own result one cycle after being presented.
- R3: Rotate left (code 0): result = {operand[6:0], C}, and the new C = operand[7].
- R4: Rotate right (code 1): result = {C, operand[7:1]}, and the new C = operand[0].
- R5: Arithmetic shift right (code 2): result = {operand[7], operand[7:1]}, and the new C = operand[0].
- R6: For codes 0 to 2, N = result[7], Z = 1 exactly when the result is 0, V = N xor C, and S = N xor V. H, T and I keep their input values.
- R7: Nibble swap (code 3): result = {operand[3:0], operand[7:4]}, and `sreg_out` equals `sreg_in`.
- R8: Flag set (code 4): `sreg_out` is `sreg_in` with bit `flag_idx` forced to 1. The result equals the operand.
- R9: Flag clear (code 5): `sreg_out` is `sreg_in` with bit `flag_idx` forced to 0. The result equals the operand.
- R10: Bit to T (code 6): T (bit 6) = operand[`bit_idx`]. All other status bits are unchanged and the result equals the operand.
- R11: T to bit (code 7): the result is the operand with bit `bit_idx` replaced by `sreg_in[6]`, and `sreg_out` equals `sreg_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| operand | input | 8 | Register operand |
| sreg_in | input | 8 | Current status byte |
| op_sel | input | 3 | Operation code |
| bit_idx | input | 3 | Operand/result bit index for codes 6 and 7 |
| flag_idx | input | 3 | Status bit index for codes 4 and 5 |
| result | output | 8 | Registered result byte |
| sreg_out | output | 8 | Registered updated status byte |

## Verification
Every result and every flag sits behind exactly one register, so each is due one clock after the edge that samples the inputs. The bench changes its inputs 1 ns after a rising edge and compares the outputs 1 ns after the next rising edge. It never reads an output in the cycle it was stimulated. The latency test issues a train of different operations on consecutive edges and checks each output against the operation of the immediately preceding edge. The bound properties use the same one-cycle relation with `|=>` and `$past`.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int DATA_W  = 8;
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int FLAG_W  = 8;
    localparam int FIDX_W  = $clog2(FLAG_W);
    localparam int HALF_W  = DATA_W / 2;

    // status bit positions
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;
    localparam int FL_I = 7;

    typedef enum logic [2:0] {
        OP_ROTL   = 3'd0,
        OP_ROTR   = 3'd1,
        OP_ASR    = 3'd2,
        OP_SWAP   = 3'd3,
        OP_FSET   = 3'd4,
        OP_FCLR   = 3'd5,
        OP_TSTORE = 3'd6,
        OP_TLOAD  = 3'd7
    } op_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [FLAG_W-1:0] flags;
    } stage_t;

    function automatic logic is_shift(input op_e op);
        return (op == OP_ROTL) || (op == OP_ROTR) || (op == OP_ASR);
    endfunction

    // flag update shared by the three shift-class operations
    function automatic logic [FLAG_W-1:0] shift_flags(
        input logic [FLAG_W-1:0] sreg,
        input logic [DATA_W-1:0] res,
        input logic              cout
    );
        logic [FLAG_W-1:0] f;
        logic n, v;
        n       = res[DATA_W-1];
        v       = n ^ cout;
        f       = sreg;
        f[FL_C] = cout;
        f[FL_Z] = ~|res;
        f[FL_N] = n;
        f[FL_V] = v;
        f[FL_S] = n ^ v;
        return f;
    endfunction

endpackage

// File: rtl/bitop_shifter.sv
module bitop_shifter
    import bitop_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  operand,
    input  logic          carry_in,
    input  logic          t_in,
    input  op_e           op,
    input  logic [IW-1:0] bit_idx,
    output logic [W-1:0]  data_out,
    output logic          carry_out
);
    localparam int HW = W / 2;

    logic [W-1:0] rotl_v, rotr_v, asr_v, tld_v, swap_v;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign rotl_v[i] = carry_in;
        end else begin : g_nlsb
            assign rotl_v[i] = operand[i-1];
        end
        if (i == W-1) begin : g_msb
            assign rotr_v[i] = carry_in;
            assign asr_v[i]  = operand[i];
        end else begin : g_nmsb
            assign rotr_v[i] = operand[i+1];
            assign asr_v[i]  = operand[i+1];
        end
        assign tld_v[i] = (bit_idx == IW'(i)) ? t_in : operand[i];
    end

    assign swap_v = {operand[HW-1:0], operand[W-1:HW]};

    always_comb begin
        unique case (op)
            OP_ROTL:  data_out = rotl_v;
            OP_ROTR:  data_out = rotr_v;
            OP_ASR:   data_out = asr_v;
            OP_SWAP:  data_out = swap_v;
            OP_TLOAD: data_out = tld_v;
            default:  data_out = operand;
        endcase
    end

    assign carry_out = (op == OP_ROTL) ? operand[W-1] : operand[0];

endmodule

// File: rtl/bitop_flag_logic.sv
module bitop_flag_logic
    import bitop_pkg::*;
(
    input  op_e               op,
    input  logic [FLAG_W-1:0] sreg_in,
    input  logic [DATA_W-1:0] res,
    input  logic              carry_out,
    input  logic              sel_bit,
    input  logic [FIDX_W-1:0] flag_idx,
    output logic [FLAG_W-1:0] sreg_next
);
    logic [FLAG_W-1:0] set_v, clr_v, tst_v;

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        assign set_v[i] = (flag_idx == FIDX_W'(i)) ? 1'b1 : sreg_in[i];
        assign clr_v[i] = (flag_idx == FIDX_W'(i)) ? 1'b0 : sreg_in[i];
        if (i == FL_T) begin : g_t
            assign tst_v[i] = sel_bit;
        end else begin : g_nt
            assign tst_v[i] = sreg_in[i];
        end
    end

    always_comb begin
        if (is_shift(op)) begin
            sreg_next = shift_flags(sreg_in, res, carry_out);
        end else begin
            unique case (op)
                OP_FSET:   sreg_next = set_v;
                OP_FCLR:   sreg_next = clr_v;
                OP_TSTORE: sreg_next = tst_v;
                default:   sreg_next = sreg_in;
            endcase
        end
    end

endmodule

// File: rtl/bitop_out_reg.sv
module bitop_out_reg
    import bitop_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  stage_t d,
    output stage_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/bitop_flag_unit.sv
module bitop_flag_unit
    import bitop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] operand,
    input  logic [FLAG_W-1:0] sreg_in,
    input  logic [2:0]        op_sel,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [FIDX_W-1:0] flag_idx,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] sreg_out
);
    op_e               op;
    logic [DATA_W-1:0] sh_data;
    logic              sh_carry;
    logic [FLAG_W-1:0] fl_next;
    stage_t            stage_d, stage_q;

    assign op = op_e'(op_sel);

    bitop_shifter #(.W(DATA_W), .IW(IDX_W)) u_shift (
        .operand   (operand),
        .carry_in  (sreg_in[FL_C]),
        .t_in      (sreg_in[FL_T]),
        .op        (op),
        .bit_idx   (bit_idx),
        .data_out  (sh_data),
        .carry_out (sh_carry)
    );

    bitop_flag_logic u_flags (
        .op        (op),
        .sreg_in   (sreg_in),
        .res       (sh_data),
        .carry_out (sh_carry),
        .sel_bit   (operand[bit_idx]),
        .flag_idx  (flag_idx),
        .sreg_next (fl_next)
    );

    assign stage_d.data  = sh_data;
    assign stage_d.flags = fl_next;

    bitop_out_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (stage_d),
        .q   (stage_q)
    );

    assign result   = stage_q.data;
    assign sreg_out = stage_q.flags;

endmodule

// File: rtl/bitop_flag_unit_chk.sv
module bitop_flag_unit_chk
    import bitop_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] operand,
    input logic [FLAG_W-1:0] sreg_in,
    input logic [2:0]        op_sel,
    input logic [IDX_W-1:0]  bit_idx,
    input logic [FIDX_W-1:0] flag_idx,
    input logic [DATA_W-1:0] result,
    input logic [FLAG_W-1:0] sreg_out
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (result == '0 && sreg_out == '0)); // R1

    AST_ROTL_CARRY: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_ROTL) |=> (sreg_out[FL_C] == $past(operand[DATA_W-1]) && result[0] == $past(sreg_in[FL_C]))); // R3

    AST_ROTR_CARRY: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_ROTR) |=> (result[DATA_W-1] == $past(sreg_in[FL_C]) && sreg_out[FL_C] == $past(operand[0]))); // R4

    AST_ASR_SIGN: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_ASR) |=> (result[DATA_W-1] == $past(operand[DATA_W-1]))); // R5

    AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_sel inside {OP_ROTL, OP_ROTR, OP_ASR}) |=> (sreg_out[FL_Z] == (result == '0) && sreg_out[FL_I:FL_H] == $past(sreg_in[FL_I:FL_H]))); // R6

    AST_SWAP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_SWAP) |=> (sreg_out == $past(sreg_in))); // R7

    AST_FSET_BIT: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_FSET) |=> (sreg_out == ($past(sreg_in) | (8'b1 << $past(flag_idx))))); // R8

    AST_FCLR_BIT: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_FCLR) |=> (sreg_out == ($past(sreg_in) & ~(8'b1 << $past(flag_idx))))); // R9

    AST_TSTORE_T: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_TSTORE) |=> (sreg_out[FL_T] == $past(operand[bit_idx]) && result == $past(operand))); // R10

    AST_TLOAD_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_TLOAD) |=> (sreg_out == $past(sreg_in) && result[$past(bit_idx)] == $past(sreg_in[FL_T]))); // R11

endmodule

bind bitop_flag_unit bitop_flag_unit_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .operand  (operand),
    .sreg_in  (sreg_in),
    .op_sel   (op_sel),
    .bit_idx  (bit_idx),
    .flag_idx (flag_idx),
    .result   (result),
    .sreg_out (sreg_out)
);

// File: tb/bitop_flag_unit_tb.sv
module bitop_flag_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] operand = '0;
    logic [7:0] sreg_in = '0;
    logic [2:0] op_sel = '0;
    logic [2:0] bit_idx = '0;
    logic [2:0] flag_idx = '0;
    logic [7:0] result;
    logic [7:0] sreg_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitop_flag_unit dut_i (
        .clk(clk), .rst(rst), .operand(operand), .sreg_in(sreg_in),
        .op_sel(op_sel), .bit_idx(bit_idx), .flag_idx(flag_idx),
        .result(result), .sreg_out(sreg_out)
    );

    task automatic check8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // present one operation, wait one edge, sample 1 ns later
    task automatic run_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] s,
                          input logic [2:0] bi, input logic [2:0] fi);
        op_sel = op; operand = a; sreg_in = s; bit_idx = bi; flag_idx = fi;
        @(posedge clk); #1;
    endtask

    // expected status after a shift-class op (R6)
    function automatic logic [7:0] exp_shift_flags(input logic [7:0] s, input logic [7:0] r, input logic c);
        logic n, v;
        logic [7:0] f;
        n = r[7]; v = n ^ c;
        f = s;
        f[0] = c; f[1] = (r == 8'h00); f[2] = n; f[3] = v; f[4] = n ^ v;
        return f;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        run_op(3'd4, 8'hA5, 8'h3C, 3'd2, 3'd7);
        check8("R1", "result in reset", result, 8'h00);
        check8("R1", "sreg in reset", sreg_out, 8'h00);
        rst = 1'b0;
    endtask

    task automatic t_rotl();
        logic [7:0] a [4] = '{8'h80, 8'h55, 8'h01, 8'hFF};
        logic [7:0] s [4] = '{8'h00, 8'hE1, 8'h20, 8'h01};
        for (int k = 0; k < 4; k++) begin
            logic [7:0] er;
            er = {a[k][6:0], s[k][0]};
            run_op(3'd0, a[k], s[k], 3'd0, 3'd0);
            check8("R3", "rotl result", result, er);
            check8("R6", "rotl flags", sreg_out, exp_shift_flags(s[k], er, a[k][7]));
        end
        // 0x80 with C=0: result 0, C=1, Z=1, N=0, V=1, S=1
        run_op(3'd0, 8'h80, 8'h00, 3'd0, 3'd0);
        check8("R6", "rotl zero corner", sreg_out, 8'h1B);
    endtask

    task automatic t_rotr();
        logic [7:0] a [3] = '{8'h01, 8'hAA, 8'h00};
        logic [7:0] s [3] = '{8'h00, 8'h01, 8'hC1};
        for (int k = 0; k < 3; k++) begin
            logic [7:0] er;
            er = {s[k][0], a[k][7:1]};
            run_op(3'd1, a[k], s[k], 3'd0, 3'd0);
            check8("R4", "rotr result", result, er);
            check8("R6", "rotr flags", sreg_out, exp_shift_flags(s[k], er, a[k][0]));
        end
    endtask

    task automatic t_asr();
        logic [7:0] a [3] = '{8'h81, 8'h7E, 8'h01};
        for (int k = 0; k < 3; k++) begin
            logic [7:0] er;
            er = {a[k][7], a[k][7:1]};
            run_op(3'd2, a[k], 8'h61, 3'd0, 3'd0);
            check8("R5", "asr result", result, er);
            check8("R6", "asr flags", sreg_out, exp_shift_flags(8'h61, er, a[k][0]));
        end
        run_op(3'd2, 8'h81, 8'h00, 3'd0, 3'd0);
        check8("R5", "asr 0x81", result, 8'hC0);
        check8("R6", "asr 0x81 flags", sreg_out, 8'h15);
    endtask

    task automatic t_swap();
        run_op(3'd3, 8'h3C, 8'hA7, 3'd0, 3'd0);
        check8("R7", "swap result", result, 8'hC3);
        check8("R7", "swap flags", sreg_out, 8'hA7);
        run_op(3'd3, 8'h00, 8'h5A, 3'd5, 3'd5);
        check8("R7", "swap zero flags", sreg_out, 8'h5A);
    endtask

    task automatic t_fset_fclr();
        for (int i = 0; i < 8; i++) begin
            run_op(3'd4, 8'h96, 8'h00, 3'(7 - i), 3'(i));
            check8("R8", "flag set", sreg_out, 8'h01 << i);
            check8("R8", "flag set result", result, 8'h96);
            run_op(3'd5, 8'h69, 8'hFF, 3'(i), 3'(i));
            check8("R9", "flag clear", sreg_out, ~(8'h01 << i));
            check8("R9", "flag clear result", result, 8'h69);
        end
    endtask

    task automatic t_bst();
        for (int i = 0; i < 8; i++) begin
            logic [7:0] es;
            es = 8'hBF;
            es[6] = 8'hA5 >> i;
            run_op(3'd6, 8'hA5, 8'hBF, 3'(i), 3'(7 - i));
            check8("R10", "bit to T flags", sreg_out, es);
            check8("R10", "bit to T result", result, 8'hA5);
        end
    endtask

    task automatic t_bld();
        for (int i = 0; i < 8; i++) begin
            run_op(3'd7, 8'h00, 8'h40, 3'(i), 3'd0);
            check8("R11", "T to bit set", result, 8'h01 << i);
            check8("R11", "T to bit flags", sreg_out, 8'h40);
            run_op(3'd7, 8'hFF, 8'hBF, 3'(i), 3'd0);
            check8("R11", "T to bit clear", result, ~(8'h01 << i));
        end
    endtask

    task automatic t_latency();
        // back-to-back: each edge's output belongs to the op of that edge only
        run_op(3'd3, 8'h12, 8'h00, 3'd0, 3'd0);
        check8("R2", "train 1", result, 8'h21);
        run_op(3'd0, 8'h12, 8'h01, 3'd0, 3'd0);
        check8("R2", "train 2", result, 8'h25);
        run_op(3'd4, 8'h77, 8'h00, 3'd0, 3'd7);
        check8("R2", "train 3 data", result, 8'h77);
        check8("R2", "train 3 flags", sreg_out, 8'h80);
        // mid-run reset
        rst = 1'b1;
        run_op(3'd4, 8'hFF, 8'hFF, 3'd0, 3'd0);
        check8("R1", "mid reset flags", sreg_out, 8'h00);
        check8("R1", "mid reset data", result, 8'h00);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        t_reset();
        t_rotl();
        t_rotr();
        t_asr();
        t_swap();
        t_fset_fclr();
        t_bst();
        t_bld();
        t_latency();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule